// File: doc/BRIEF.md
# Masked Interval Port Eligibility Unit

This block decides which output ports of a switch may carry a packet, based only on the packet's destination identifier. The switch has 2k ports. Ports 0 to k-1 lead down the tree and ports k to 2k-1 lead up. Each port holds four configuration registers: a lower bound, an upper bound, a bit mask and a deference vector. The mask is applied to the destination and to both bounds. The masked destination is then compared against the port's interval, which may wrap around the top of the identifier space. A port that matches still drops out when any port named in its deference vector also matches.

The eligible-port vector and a valid flag are combinational functions of the destination and the stored configuration. A system that routes deterministically loads the deference vectors so that exactly one port survives. An adaptive system can instead read several surviving ports as its candidate set. Configuration is written one register at a time, selected by a port index and a register selector. Each write lands on the next rising clock edge.

Top module: `ivRouteTop`

## Requirements
- R1: After reset every bound, mask and deference vector is zero, so every port is eligible and the valid flag is high for any destination.
- R2: When a port's masked upper bound is not below its masked lower bound, the port matches exactly when the masked destination lies between the two masked bounds, both bounds included.
- R3: When a port's masked upper bound is below its masked lower bound, the interval wraps, and the port matches when the masked destination is at least the lower bound or at most the upper bound.
- R4: The mask is ANDed with the destination and with both bounds before comparison, so a destination bit whose mask bit is zero has no effect on that port's match.
- R5: Port i is eligible only when it matches and no port j with bit j set in port i's deference vector also matches.
- R6: A write with the write enable high stores the data's low bits into the register chosen by the port index and the selector: 0 is the lower bound, 1 the upper bound, 2 the mask and 3 the deference vector. The write takes effect at the next rising edge and leaves every other register unchanged.
- R7: The valid flag is low exactly when no port is eligible.
- R8: With the deterministic tree configuration, a matching downward port is the only eligible port. When no downward port matches, exactly the upward port chosen by the masked destination digit is eligible. In this configuration each upward port defers to all downward ports, downward ports use an all-ones mask, and downward ports have an empty deference vector.
- R9: The outputs follow a change of the destination within the same cycle, with no clock edge in between.
- R10: While a write is pending in the same cycle as a lookup, the outputs reflect the old configuration until the edge and the new one after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgPort | input | PORT_W | Port index of the register to write |
| cfgSel | input | 2 | Register selector (0 lower, 1 upper, 2 mask, 3 deference) |
| cfgData | input | CFG_W | Write data, low bits used |
| destId | input | DEST_W | Packet destination identifier |
| portEligible | output | 2*ARITY | One bit per port, set when that port may be used |
| routeValid | output | 1 | High when at least one port is eligible |

## Verification
A configuration write and a lookup can occur in the same cycle. The stored registers change on the edge, while the lookup path is purely combinational. The bench holds a destination whose answer depends on the register being rewritten, then raises the write strobe. It checks the outputs once before the rising edge, where they must match the old configuration, and again after the edge, where they must match the new one. Every other sweep compares all destinations against an arithmetic model built from the values the bench itself wrote.

// File: rtl/ivRoutePkg.sv
package ivRoutePkg;

  // Register selector codes used on cfgSel
  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_MASK = 2'd2,
    SEL_PREF = 2'd3
  } cfgSelE;

  // Strobes passed from the control decode to the datapath
  typedef struct packed {
    logic wrLo;
    logic wrHi;
    logic wrMask;
    logic wrPref;
  } cfgStrobeT;

endpackage

// File: rtl/ivRouteCtrl.sv
module ivRouteCtrl
  import ivRoutePkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 2
) (
  input  logic                 cfgWrEn,
  input  logic [PORT_W-1:0]    cfgPort,
  input  logic [1:0]           cfgSel,
  output cfgStrobeT            strobe,
  output logic [NUM_PORTS-1:0] portSel
);

  cfgSelE selCode;

  always_comb begin
    selCode = cfgSelE'(cfgSel);
    strobe  = '0;
    if (cfgWrEn) begin
      unique case (selCode)
        SEL_LO:   strobe.wrLo   = 1'b1;
        SEL_HI:   strobe.wrHi   = 1'b1;
        SEL_MASK: strobe.wrMask = 1'b1;
        SEL_PREF: strobe.wrPref = 1'b1;
        default:  strobe        = '0;
      endcase
    end
  end

  // One-hot decode of the addressed port
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    assign portSel[p] = cfgWrEn && (cfgPort == PORT_W'(p));
  end

endmodule

// File: rtl/ivIntervalMatch.sv
module ivIntervalMatch #(
  parameter int DEST_W = 3
) (
  input  logic [DEST_W-1:0] dest,
  input  logic [DEST_W-1:0] loBound,
  input  logic [DEST_W-1:0] hiBound,
  input  logic [DEST_W-1:0] mask,
  output logic              hit
);

  logic [DEST_W-1:0] destM;
  logic [DEST_W-1:0] loM;
  logic [DEST_W-1:0] hiM;
  logic              wrapIv;
  logic              geLo;
  logic              leHi;

  always_comb begin
    destM  = dest & mask;
    loM    = loBound & mask;
    hiM    = hiBound & mask;
    // wrap depends on configuration only, off the destination path
    wrapIv = hiM < loM;
    geLo   = destM >= loM;
    leHi   = destM <= hiM;
    hit    = wrapIv ? (geLo || leHi) : (geLo && leHi);
  end

endmodule

// File: rtl/ivRouteDatapath.sv
module ivRouteDatapath
  import ivRoutePkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int DEST_W    = 3,
  parameter int CFG_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cfgStrobeT            strobe,
  input  logic [NUM_PORTS-1:0] portSel,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic [DEST_W-1:0]    destId,
  output logic [NUM_PORTS-1:0] portEligible,
  output logic                 routeValid
);

  logic [NUM_PORTS-1:0][DEST_W-1:0]    loReg;
  logic [NUM_PORTS-1:0][DEST_W-1:0]    hiReg;
  logic [NUM_PORTS-1:0][DEST_W-1:0]    maskReg;
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] prefReg;
  logic [NUM_PORTS-1:0]                matchVec;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loReg[p]   <= '0;
        hiReg[p]   <= '0;
        maskReg[p] <= '0;
        prefReg[p] <= '0;
      end else if (portSel[p]) begin
        if (strobe.wrLo)   loReg[p]   <= cfgData[DEST_W-1:0];
        if (strobe.wrHi)   hiReg[p]   <= cfgData[DEST_W-1:0];
        if (strobe.wrMask) maskReg[p] <= cfgData[DEST_W-1:0];
        if (strobe.wrPref) prefReg[p] <= cfgData[NUM_PORTS-1:0];
      end
    end

    ivIntervalMatch #(.DEST_W(DEST_W)) u_match (
      .dest    (destId),
      .loBound (loReg[p]),
      .hiBound (hiReg[p]),
      .mask    (maskReg[p]),
      .hit     (matchVec[p])
    );

    // drop the port when a port it defers to is also matching
    assign portEligible[p] = matchVec[p] && ((prefReg[p] & matchVec) == '0);
  end

  assign routeValid = |portEligible;

endmodule

// File: rtl/ivRouteTop.sv
module ivRouteTop
  import ivRoutePkg::*;
#(
  parameter int ARITY  = 2,
  parameter int STAGES = 3,
  localparam int LOG_K     = (ARITY > 1) ? $clog2(ARITY) : 1,
  localparam int DEST_W    = STAGES * LOG_K,
  localparam int NUM_PORTS = 2 * ARITY,
  localparam int PORT_W    = $clog2(NUM_PORTS),
  localparam int CFG_W     = (DEST_W > NUM_PORTS) ? DEST_W : NUM_PORTS
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [PORT_W-1:0]    cfgPort,
  input  logic [1:0]           cfgSel,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic [DEST_W-1:0]    destId,
  output logic [NUM_PORTS-1:0] portEligible,
  output logic                 routeValid
);

  cfgStrobeT            strobe;
  logic [NUM_PORTS-1:0] portSel;

  ivRouteCtrl #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_ctrl (
    .cfgWrEn (cfgWrEn),
    .cfgPort (cfgPort),
    .cfgSel  (cfgSel),
    .strobe  (strobe),
    .portSel (portSel)
  );

  ivRouteDatapath #(.NUM_PORTS(NUM_PORTS), .DEST_W(DEST_W), .CFG_W(CFG_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .portSel      (portSel),
    .cfgData      (cfgData),
    .destId       (destId),
    .portEligible (portEligible),
    .routeValid   (routeValid)
  );

endmodule

// File: rtl/ivRouteChk.sv
module ivRouteChk #(
  parameter int NUM_PORTS = 4,
  parameter int DEST_W    = 3,
  parameter int CFG_W     = 4,
  parameter int PORT_W    = 2
) (
  input logic                                clk,
  input logic                                rstN,
  input logic                                cfgWrEn,
  input logic [PORT_W-1:0]                   cfgPort,
  input logic [1:0]                          cfgSel,
  input logic [CFG_W-1:0]                    cfgData,
  input logic [NUM_PORTS-1:0]                portEligible,
  input logic                                routeValid,
  input logic [NUM_PORTS-1:0]                matchVec,
  input logic [NUM_PORTS-1:0][DEST_W-1:0]    loReg,
  input logic [NUM_PORTS-1:0][DEST_W-1:0]    hiReg,
  input logic [NUM_PORTS-1:0][DEST_W-1:0]    maskReg,
  input logic [NUM_PORTS-1:0][NUM_PORTS-1:0] prefReg
);

  // R5: eligibility is a subset of the interval matches
  a_r5_elig_implies_match: assert property (@(posedge clk) disable iff (!rstN)
    (portEligible & ~matchVec) == '0);

  // R5: an eligible port never has a matching port it defers to
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pref
    a_r5_pref_clear: assert property (@(posedge clk) disable iff (!rstN)
      portEligible[p] |-> ((prefReg[p] & matchVec) == '0));
  end

  // R7: valid flag agrees with the eligible vector
  a_r7_valid_iff: assert property (@(posedge clk) disable iff (!rstN)
    routeValid == (portEligible != '0));

  // R6: each register type lands after a write
  a_r6_write_lo: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgSel == 2'd0) |=> loReg[$past(cfgPort)] == $past(cfgData[DEST_W-1:0]));
  a_r6_write_hi: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgSel == 2'd1) |=> hiReg[$past(cfgPort)] == $past(cfgData[DEST_W-1:0]));
  a_r6_write_mask: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgSel == 2'd2) |=> maskReg[$past(cfgPort)] == $past(cfgData[DEST_W-1:0]));
  a_r6_write_pref: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgSel == 2'd3) |=> prefReg[$past(cfgPort)] == $past(cfgData[NUM_PORTS-1:0]));

  // R6: no write, no change
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> ($stable(loReg) && $stable(hiReg) && $stable(maskReg) && $stable(prefReg)));

endmodule

bind ivRouteTop ivRouteChk #(
  .NUM_PORTS (NUM_PORTS),
  .DEST_W    (DEST_W),
  .CFG_W     (CFG_W),
  .PORT_W    (PORT_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgWrEn      (cfgWrEn),
  .cfgPort      (cfgPort),
  .cfgSel       (cfgSel),
  .cfgData      (cfgData),
  .portEligible (portEligible),
  .routeValid   (routeValid),
  .matchVec     (u_dp.matchVec),
  .loReg        (u_dp.loReg),
  .hiReg        (u_dp.hiReg),
  .maskReg      (u_dp.maskReg),
  .prefReg      (u_dp.prefReg)
);

// File: tb/ivRouteTop_bench.sv
module ivRouteTop_bench;

  localparam int NP = 4;
  localparam int DW = 3;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [1:0]    cfgPort = '0;
  logic [1:0]    cfgSel = '0;
  logic [CW-1:0] cfgData = '0;
  logic [DW-1:0] destId = '0;
  logic [NP-1:0] portEligible;
  logic          routeValid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench-side record of written configuration
  logic [DW-1:0] mLo   [NP];
  logic [DW-1:0] mHi   [NP];
  logic [DW-1:0] mMask [NP];
  logic [NP-1:0] mPref [NP];

  always #5 clk = ~clk;

  ivRouteTop u_ivRouteTop (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgPort(cfgPort),
    .cfgSel(cfgSel), .cfgData(cfgData), .destId(destId),
    .portEligible(portEligible), .routeValid(routeValid)
  );

  function automatic logic [NP-1:0] expElig(input int d);
    logic [NP-1:0] m;
    logic [NP-1:0] e;
    for (int p = 0; p < NP; p++) begin
      int dm = d & mMask[p];
      int lm = mLo[p] & mMask[p];
      int hm = mHi[p] & mMask[p];
      if (lm <= hm) m[p] = (dm >= lm) && (dm <= hm);
      else          m[p] = (dm >= lm) || (dm <= hm);
    end
    for (int p = 0; p < NP; p++) e[p] = m[p] && ((mPref[p] & m) == '0);
    return e;
  endfunction

  task automatic check(input string tag, input logic [NP-1:0] got, input logic [NP-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // R9: destination swept with no clock edge between steps
  task automatic sweep(input string tag);
    for (int d = 0; d < 8; d++) begin
      logic [NP-1:0] e;
      destId = DW'(d);
      #1;
      e = expElig(d);
      check(tag, portEligible, e);
      check({tag, " valid R7"}, {3'b0, routeValid}, {3'b0, (e != '0)});
    end
  endtask

  task automatic writeCfg(input int port, input int sel, input int data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgPort = 2'(port); cfgSel = 2'(sel); cfgData = CW'(data);
    @(negedge clk);
    cfgWrEn = 1'b0;
    case (sel)
      0: mLo[port]   = DW'(data);
      1: mHi[port]   = DW'(data);
      2: mMask[port] = DW'(data);
      default: mPref[port] = NP'(data);
    endcase
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      mLo[p] = '0; mHi[p] = '0; mMask[p] = '0; mPref[p] = '0;
    end
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state, all ports eligible
    sweep("R1 reset");
    check("R1 reset all ones", expElig(5), 4'b1111);

    // R2: plain intervals, full mask
    writeCfg(0, 2, 7); writeCfg(0, 0, 2); writeCfg(0, 1, 5);
    writeCfg(1, 2, 7); writeCfg(1, 0, 6); writeCfg(1, 1, 6);
    // R3: wrapping interval 5..1 on port 2
    writeCfg(2, 2, 7); writeCfg(2, 0, 5); writeCfg(2, 1, 1);
    writeCfg(3, 2, 7); writeCfg(3, 0, 3); writeCfg(3, 1, 3);
    sweep("R2 R3 intervals");

    // R4: partial mask 011, port0 bounds 1..2 with high bit ignored
    writeCfg(0, 2, 3); writeCfg(0, 0, 5); writeCfg(0, 1, 2);
    sweep("R4 mask");
    destId = 3'd6; #1; check("R4 bit2 ignored", {3'b0, portEligible[0]}, 4'b0001);

    // R5: port 2 defers to port 0 and 1
    writeCfg(2, 3, 4'b0011);
    sweep("R5 prune");

    // R7: all ports match only destination 0
    for (int p = 0; p < NP; p++) begin
      writeCfg(p, 2, 7); writeCfg(p, 0, 0); writeCfg(p, 1, 0); writeCfg(p, 3, 0);
    end
    sweep("R7 none eligible");

    // R8: deterministic tree config, stage 0 switch covering dests 0 and 1
    writeCfg(0, 0, 0); writeCfg(0, 1, 0);
    writeCfg(1, 0, 1); writeCfg(1, 1, 1);
    writeCfg(2, 2, 1); writeCfg(2, 0, 0); writeCfg(2, 1, 0); writeCfg(2, 3, 4'b0011);
    writeCfg(3, 2, 1); writeCfg(3, 0, 1); writeCfg(3, 1, 1); writeCfg(3, 3, 4'b0011);
    for (int d = 0; d < 8; d++) begin
      logic [NP-1:0] e;
      e = (d < 2) ? NP'(1 << d) : ((d % 2 == 1) ? 4'b1000 : 4'b0100);
      destId = DW'(d); #1;
      check("R8 deterministic", portEligible, e);
    end

    // R10: write and lookup in the same cycle, port1 upper bound 1 -> 3
    @(negedge clk);
    destId = 3'd3;
    cfgWrEn = 1'b1; cfgPort = 2'd1; cfgSel = 2'd1; cfgData = 4'd3;
    #1; check("R10 before edge", portEligible, 4'b1000);
    @(posedge clk); #1;
    check("R10 after edge", portEligible, 4'b0010);
    @(negedge clk);
    cfgWrEn = 1'b0;
    mHi[1] = 3'd3;
    // R6: only the addressed register changed
    sweep("R6 isolated write");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule